// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block steers a small 8-bit processor core into and back out of its low-power sleep state. The instruction decoder hands it a sleep strobe and a clear-watchdog strobe. The block samples both on the last phase of the instruction cycle, which is the point where such an instruction would commit. At that same phase it samples the wake condition: at least one interrupt source whose enable bit and flag bit are both set. If the wake condition is already present when a sleep would commit, the sleep is turned into a no-op. If it is not present, the core sleeps: the pipeline is stalled, the watchdog is cleared and the power-down status bit drops.

Wake-up happens as soon as any enabled source raises its flag. The global interrupt enable plays no part in this. In crystal-type oscillator modes the block then runs a 1024-period oscillator start-up count before it releases the stall. In RC mode the stall is released at once. After release, the instruction that follows the sleep executes. If the global interrupt enable is set, one dummy instruction cycle follows and the program counter is redirected to the interrupt vector. If it is clear, execution simply continues in-line.

The state machine has five states:
- RUN: normal execution.
- SLEEP: the core is stalled and waiting for a wake condition.
- STARTUP: the oscillator start-up count is running.
- POSTWAKE: the instruction after the sleep executes.
- DUMMY: the inserted no-operation cycle before the vector branch.

The transitions are:
- RUN→SLEEP on a committed sleep.
- SLEEP→STARTUP on a wake condition in crystal mode.
- SLEEP→POSTWAKE on a wake condition in RC mode.
- STARTUP→POSTWAKE when the start-up count reaches terminal count.
- POSTWAKE→DUMMY at the end of the cycle when the global enable is set.
- POSTWAKE→RUN at the end of the cycle when the global enable is clear.
- DUMMY→RUN at the end of the dummy cycle.

Top module: `swc_sleep_ctrl`

## Requirements
- R1: After reset, `pd_bit`=1, `to_bit`=1, `q_phase`=0, and `stall`, `wdt_clr`, `ost_ready`, `dummy_cycle` and `vec_redirect` are all 0.
- R2: The wake condition is true when any source has `int_en[i]`=1 and `int_flag[i]`=1. It does not depend on `gie`. An enable bit without its own flag bit, or a flag bit without its own enable bit, neither wakes the core nor blocks a sleep.
- R3: A sleep that commits in RUN with `q_phase`=3 while no wake condition is present sets `pd_bit`=0 and `to_bit`=1. It gives a one-clock `wdt_clr` pulse, and `stall` is 1 from the next clock.
- R4: A sleep that commits while a wake condition is present is a no-op. `pd_bit` and `to_bit` keep their values, `wdt_clr` stays 0 and `stall` stays 0.
- R5: A wake condition that appears after the sleep has committed wakes the core. `pd_bit` remains 0 afterwards.
- R6: With `osc_rc`=0, `stall` stays high for exactly 1024 clocks (2^10 oscillator periods) after the wake is detected. `ost_ready` is high for exactly one clock, which is the last clock of that count.
- R7: With `osc_rc`=1, `stall` falls at the first clock edge after the wake is detected, and `ost_ready` never rises.
- R8: With `gie`=1 at the end of the post-wake instruction cycle, that cycle (4 clocks) is followed by one dummy instruction cycle with `dummy_cycle`=1. During the dummy cycle, `vec_redirect` pulses for one clock in phase 3, with `vec_addr`=0x004.
- R9: With `gie`=0, no dummy cycle and no redirect follow the post-wake instruction.
- R10: A clear-watchdog that commits in RUN at `q_phase`=3 sets `pd_bit`=1 and `to_bit`=1 and gives a one-clock `wdt_clr` pulse.
- R11: A `wdt_tmo` pulse clears `to_bit` to 0 when no clear-watchdog commits on the same clock.
- R12: `q_phase` counts 0,1,2,3 repeatedly while the core runs, and holds at 0 whenever `stall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period per Q phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_cmd | input | 1 | Decoded sleep instruction, sampled at phase 3 |
| clrwdt_cmd | input | 1 | Decoded clear-watchdog instruction, sampled at phase 3 |
| wdt_tmo | input | 1 | Watchdog expiry strobe; clears the timeout bit |
| int_en | input | N_SRC | Per-source interrupt enable bits |
| int_flag | input | N_SRC | Per-source interrupt flag bits |
| gie | input | 1 | Global interrupt enable |
| osc_rc | input | 1 | 1 = RC oscillator (no start-up delay), 0 = crystal type |
| q_phase | output | 2 | Current phase of the instruction cycle (0..3) |
| pd_bit | output | 1 | Power-down status, 0 after a real sleep |
| to_bit | output | 1 | Timeout status, 0 after a watchdog expiry |
| wdt_clr | output | 1 | One-clock clear to watchdog and its scalers |
| stall | output | 1 | Holds the pipeline and program counter |
| ost_ready | output | 1 | Start-up count at terminal value |
| dummy_cycle | output | 1 | Inserted no-operation instruction cycle |
| vec_redirect | output | 1 | Load the program counter with `vec_addr` |
| vec_addr | output | PC_W | Interrupt vector address |

## Verification
The bench drives sleep requests against many enable/flag patterns. The aim is to catch a design that ANDs the wrong bits, ORs enable and flag, or gates the wake with `gie`. Such a design would sleep when it should not, or would no-op when it should sleep. Each no-op attempt is preceded by a timeout pulse, so that a design that touches the status bits or clears the watchdog on a no-op shows a changed `to_bit` or a stray `wdt_clr`. The start-up window is counted clock by clock, so an off-by-one terminal count, or a delay applied in RC mode, gives the wrong stall length. The post-wake window is scanned for dummy cycles and redirect pulses, so a design that skips the in-line instruction, omits the dummy cycle, or branches with `gie` clear gives the wrong counts.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SLEEP    = 3'd1,
        ST_STARTUP  = 3'd2,
        ST_POSTWAKE = 3'd3,
        ST_DUMMY    = 3'd4
    } swc_state_e;

    localparam int unsigned QPH_W    = 2;
    localparam logic [1:0]  QPH_LAST = 2'd3;

endpackage

// File: rtl/swc_qphase.sv
`timescale 1ns/1ps
// Four-phase instruction-cycle sequencer; frozen at phase 0 while halted.
module swc_qphase
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    output logic [QPH_W-1:0] qph,
    output logic             q_last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qph <= '0;
        end else if (!run_en) begin
            qph <= '0;
        end else begin
            qph <= qph + 1'b1;
        end
    end

    assign q_last = (qph == QPH_LAST);

endmodule

// File: rtl/swc_wake_detect.sv
`timescale 1ns/1ps
// Any source with both its enable and flag set raises the wake condition.
module swc_wake_detect #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] flag,
    output logic             wake
);

    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = en[g] & flag[g];
    end

    assign wake = |hit;

endmodule

// File: rtl/swc_ost_counter.sv
`timescale 1ns/1ps
// Oscillator start-up timer: counts 2**OST_W periods while enabled.
module swc_ost_counter #(
    parameter int OST_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    logic [OST_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == {OST_W{1'b1}});

endmodule

// File: rtl/swc_sleep_ctrl.sv
`timescale 1ns/1ps
// Sleep entry / wake-up sequencer for a small processor core.
module swc_sleep_ctrl
    import swc_pkg::*;
#(
    parameter int              N_SRC    = 4,
    parameter int              OST_W    = 10,
    parameter int              PC_W     = 13,
    parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_cmd,
    input  logic             clrwdt_cmd,
    input  logic             wdt_tmo,
    input  logic [N_SRC-1:0] int_en,
    input  logic [N_SRC-1:0] int_flag,
    input  logic             gie,
    input  logic             osc_rc,
    output logic [1:0]       q_phase,
    output logic             pd_bit,
    output logic             to_bit,
    output logic             wdt_clr,
    output logic             stall,
    output logic             ost_ready,
    output logic             dummy_cycle,
    output logic             vec_redirect,
    output logic [PC_W-1:0]  vec_addr
);

    swc_state_e state_q, state_d;

    logic wake;
    logic q_last;
    logic run_en;
    logic ost_run;
    logic ost_done;
    logic commit_sleep;
    logic commit_clr;

    // ---------------- sub-blocks ----------------
    swc_qphase u_qph (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .qph    (q_phase),
        .q_last (q_last)
    );

    swc_wake_detect #(.N_SRC(N_SRC)) u_wake (
        .en   (int_en),
        .flag (int_flag),
        .wake (wake)
    );

    swc_ost_counter #(.OST_W(OST_W)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ost_run),
        .done  (ost_done)
    );

    // Commit decisions at the final phase of a running instruction cycle.
    assign commit_sleep = (state_q == ST_RUN) && q_last && sleep_cmd && !wake;
    assign commit_clr   = (state_q == ST_RUN) && q_last && clrwdt_cmd;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (commit_sleep) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake) state_d = osc_rc ? ST_POSTWAKE : ST_STARTUP;
            end
            ST_STARTUP: begin
                if (ost_done) state_d = ST_POSTWAKE;
            end
            ST_POSTWAKE: begin
                if (q_last) state_d = gie ? ST_DUMMY : ST_RUN;
            end
            ST_DUMMY: begin
                if (q_last) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        stall        = 1'b0;
        ost_run      = 1'b0;
        dummy_cycle  = 1'b0;
        vec_redirect = 1'b0;
        unique case (state_q)
            ST_RUN:      ;
            ST_SLEEP:    stall = 1'b1;
            ST_STARTUP: begin
                stall   = 1'b1;
                ost_run = 1'b1;
            end
            ST_POSTWAKE: ;
            ST_DUMMY: begin
                dummy_cycle  = 1'b1;
                vec_redirect = q_last;
            end
            default:     ;
        endcase
    end

    assign run_en    = !stall;
    assign ost_ready = ost_done;
    assign vec_addr  = VEC_ADDR;

    // ---------------- status bits and watchdog clear ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_bit  <= 1'b1;
            to_bit  <= 1'b1;
            wdt_clr <= 1'b0;
        end else begin
            wdt_clr <= commit_clr | commit_sleep;
            if (commit_clr) begin
                pd_bit <= 1'b1;
                to_bit <= 1'b1;
            end else if (commit_sleep) begin
                pd_bit <= 1'b0;
                to_bit <= 1'b1;
            end else if (wdt_tmo) begin
                to_bit <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/swc_sleep_ctrl_chk.sv
`timescale 1ns/1ps
module swc_sleep_ctrl_chk
    import swc_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_cmd,
    input logic             clrwdt_cmd,
    input logic             wdt_tmo,
    input logic [N_SRC-1:0] int_en,
    input logic [N_SRC-1:0] int_flag,
    input logic             osc_rc,
    input logic [1:0]       q_phase,
    input logic             pd_bit,
    input logic             to_bit,
    input logic             wdt_clr,
    input logic             stall,
    input logic             ost_ready,
    input logic             dummy_cycle,
    input logic             vec_redirect,
    input swc_state_e       st
);

    logic wake_c;
    assign wake_c = |(int_en & int_flag);

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && q_phase == 2'd3 && sleep_cmd && !wake_c && !clrwdt_cmd)
        |=> (stall && !pd_bit && to_bit && wdt_clr));

    p_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && q_phase == 2'd3 && sleep_cmd && wake_c && !clrwdt_cmd && !wdt_tmo)
        |=> (!stall && !wdt_clr && $stable(pd_bit) && $stable(to_bit)));

    p_sleep_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && !wake_c) |=> stall);

    p_ready_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ost_ready |=> !stall);

    p_startup_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STARTUP && !ost_ready) |=> stall);

    p_rc_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && wake_c && osc_rc) |=> (!stall && !ost_ready));

    p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_redirect |-> (dummy_cycle && q_phase == 2'd3));

    p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && q_phase == 2'd3 && clrwdt_cmd) |=> (pd_bit && to_bit && wdt_clr));

    p_tmo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tmo && !clrwdt_cmd && !sleep_cmd) |=> !to_bit);

    p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (q_phase == 2'd0));

endmodule

bind swc_sleep_ctrl swc_sleep_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_cmd    (sleep_cmd),
    .clrwdt_cmd   (clrwdt_cmd),
    .wdt_tmo      (wdt_tmo),
    .int_en       (int_en),
    .int_flag     (int_flag),
    .osc_rc       (osc_rc),
    .q_phase      (q_phase),
    .pd_bit       (pd_bit),
    .to_bit       (to_bit),
    .wdt_clr      (wdt_clr),
    .stall        (stall),
    .ost_ready    (ost_ready),
    .dummy_cycle  (dummy_cycle),
    .vec_redirect (vec_redirect),
    .st           (state_q)
);

// File: tb/swc_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module swc_sleep_ctrl_tb_top;

    localparam int N_SRC = 4;
    localparam int PC_W  = 13;
    localparam int OST_N = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_cmd = 1'b0;
    logic             clrwdt_cmd = 1'b0;
    logic             wdt_tmo = 1'b0;
    logic [N_SRC-1:0] int_en = '0;
    logic [N_SRC-1:0] int_flag = '0;
    logic             gie = 1'b0;
    logic             osc_rc = 1'b1;
    logic [1:0]       q_phase;
    logic             pd_bit, to_bit, wdt_clr, stall, ost_ready;
    logic             dummy_cycle, vec_redirect;
    logic [PC_W-1:0]  vec_addr;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    swc_sleep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .clrwdt_cmd(clrwdt_cmd),
        .wdt_tmo(wdt_tmo), .int_en(int_en), .int_flag(int_flag), .gie(gie),
        .osc_rc(osc_rc), .q_phase(q_phase), .pd_bit(pd_bit), .to_bit(to_bit),
        .wdt_clr(wdt_clr), .stall(stall), .ost_ready(ost_ready),
        .dummy_cycle(dummy_cycle), .vec_redirect(vec_redirect), .vec_addr(vec_addr)
    );

    // {en[3:0], flag[3:0], expect_sleep}
    localparam logic [8:0] VEC_TBL [7] = '{
        9'b0000_0000_1,
        9'b1111_0000_1,
        9'b0000_1111_1,
        9'b0101_1010_1,
        9'b0100_0100_0,
        9'b1000_1001_0,
        9'b0011_0001_0
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_q_last();
        @(negedge clk);
        while (q_phase != 2'd3) @(negedge clk);
    endtask

    task automatic issue_sleep();
        wait_q_last();
        sleep_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
    endtask

    task automatic issue_clrwdt();
        wait_q_last();
        clrwdt_cmd = 1'b1;
        @(negedge clk);
        clrwdt_cmd = 1'b0;
    endtask

    task automatic pulse_tmo();
        @(negedge clk);
        wdt_tmo = 1'b1;
        @(negedge clk);
        wdt_tmo = 1'b0;
    endtask

    // Called at a negedge while asleep: raise a wake source and follow the sequence.
    task automatic wake_and_follow(input string rs, input int exp_stall, input int exp_ready,
                                   input string rp, input int exp_dummy, input int exp_redir);
        int ns = 0;
        int nr = 0;
        int nd = 0;
        int nv = 0;
        int bad_ph = 0;
        int_en[0]   = 1'b1;
        int_flag[0] = 1'b1;
        @(negedge clk);
        while (stall && ns < 5000) begin
            if (ost_ready) nr++;
            ns++;
            @(negedge clk);
        end
        int_en   = '0;
        int_flag = '0;
        chk({rs, " stall length"}, ns, exp_stall);
        chk({rs, " ost_ready pulses"}, nr, exp_ready);
        for (int k = 0; k < 12; k++) begin
            if (dummy_cycle) nd++;
            if (vec_redirect) begin
                nv++;
                if (q_phase != 2'd3 || vec_addr != 13'h0004) bad_ph++;
            end
            @(negedge clk);
        end
        chk({rp, " dummy clocks"}, nd, exp_dummy);
        chk({rp, " redirect pulses"}, nv, exp_redir);
        chk({rp, " redirect phase/addr"}, bad_ph, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pd_bit", pd_bit, 1);
        chk("R1 to_bit", to_bit, 1);
        chk("R1 q_phase", q_phase, 0);
        chk("R1 outputs idle", {stall, wdt_clr, ost_ready, dummy_cycle, vec_redirect}, 0);
        // R12 phase rotation
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R12 q_phase running", q_phase, k % 4);
        end

        // Vector table: sleep vs no-op decision
        for (int i = 0; i < 7; i++) begin
            logic [8:0] v;
            v      = VEC_TBL[i];
            gie    = i[0];
            osc_rc = 1'b1;
            issue_clrwdt();
            pulse_tmo();
            int_en   = v[8:5];
            int_flag = v[4:1];
            issue_sleep();
            if (v[0]) begin
                chk("R3 pd_bit after sleep", pd_bit, 0);
                chk("R3 to_bit after sleep", to_bit, 1);
                chk("R3 wdt_clr pulse", wdt_clr, 1);
                chk("R3 stall", stall, 1);
                @(negedge clk);
                chk("R3 wdt_clr one clock", wdt_clr, 0);
                chk("R2 no wake without matching pair", stall, 1);
                int_en   = '0;
                int_flag = '0;
                // R5: wake after commit; R7 RC; R8/R9 by gie; R2 gie-independent
                if (gie)
                    wake_and_follow("R7", 0, 0, "R8", 4, 1);
                else
                    wake_and_follow("R7", 0, 0, "R9", 0, 0);
                chk("R5 pd_bit stays low after wake", pd_bit, 0);
            end else begin
                chk("R4 pd_bit unchanged", pd_bit, 1);
                chk("R4 to_bit unchanged", to_bit, 0);
                chk("R4 no wdt_clr", wdt_clr, 0);
                chk("R4 no stall", stall, 0);
                int_en   = '0;
                int_flag = '0;
            end
        end

        // Crystal mode with start-up count, gie set
        osc_rc = 1'b0;
        gie    = 1'b1;
        issue_sleep();
        repeat (5) begin
            @(negedge clk);
            chk("R12 q_phase held in sleep", q_phase, 0);
        end
        wake_and_follow("R6", OST_N, 1, "R8", 4, 1);

        // R10 clear-watchdog restores status
        chk("R10 pd_bit before clear", pd_bit, 0);
        issue_clrwdt();
        chk("R10 pd_bit", pd_bit, 1);
        chk("R10 to_bit", to_bit, 1);
        chk("R10 wdt_clr", wdt_clr, 1);

        // R11 timeout clears to_bit
        pulse_tmo();
        chk("R11 to_bit", to_bit, 0);
        chk("R11 pd_bit untouched", pd_bit, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule